// File: doc/BRIEF.md
# USB Endpoint Buffer Length Manager

This block keeps the byte bookkeeping for one USB endpoint that owns a transmit (IN) buffer and a receive (OUT) buffer. It sits between a processor-side data port and the packet engine that moves packets on the bus. The buffer memory itself is not part of the block. It tracks, for each direction, the maximum packet size, the data count (transfer length still to go, or bytes still unread) and the data-port pointer. From these it decides when a transmit packet is ready and how long it is, and when a receive buffer may be refilled.

On the transmit side, firmware programs a transfer length and streams bytes through the port in 8-bit or 16-bit accesses. The block marks the buffer ready whenever a full maximum-size packet, or the final short remainder, has been written. It lowers the count by the bytes the engine reports as sent. It appends a zero-length packet when the transfer ends on an exact packet boundary, unless that has been disabled. On the receive side, each accepted packet loads the count with its length. The buffer frees itself once that many bytes have been read, and it refuses new packets while it still holds data.

Top module: `ep_buflen_mgr`

## Requirements
- R1: A data-port access with `portWide`=1 moves the selected buffer's pointer by 2 and with `portWide`=0 by 1. A wide transmit write moves the pointer by only 1 when one byte of room is left before the packet limit.
- R2: A wide receive read when exactly one unread byte remains moves the pointer by 1, and `portLowOnly` is 1 while such a read is presented (`selTx`=0, `portWide`=1, `rxFull`=1, `rxCount`=1).
- R3: Writing the maximum packet size (`mpsWr`) loads it and reloads the selected buffer's count with the same value. A later length write (`lenWr`) replaces the count.
- R4: `busReset` zeroes both counts and both pointers, and clears `txReady`, `rxFull` and `rxShort`. The programmed maximum packet sizes are kept.
- R5: With a nonzero transmit count, the transmit buffer becomes ready (`txReady`=1) in the same cycle as the write that brings the pointer to min(count, max packet size). `txPktLen` then gives that byte total.
- R6: A `txSent` report while ready lowers `txCount` by `txSentBytes` (saturating at 0) and zeroes the pointer. The buffer then leaves the ready state, unless R7 applies.
- R7: If a sent packet of exactly max-packet-size bytes brings a nonzero count to 0 and `cfgNoEmpty`=0, the buffer stays ready with `txPktLen`=0 (a zero-length packet). A short final packet, or `cfgNoEmpty`=1, ends the transfer with `txReady`=0.
- R8: An accepted `rxPkt` loads `rxCount` with `rxBytes`, zeroes `rxPtr` and sets `rxFull`. It sets `rxShort` to (`rxBytes` < max packet size). Reading the last counted byte clears `rxFull`.
- R9: `rxPkt` is ignored while `rxFull`=1 (count unchanged, `rxAccept`=0). `clearCmd` frees the receive buffer and zeroes its count.
- R10: `validateCmd` makes the transmit buffer ready with the bytes written so far. A validate, or a port write, while the buffer is already ready is ignored.
- R11: A buffer whose maximum packet size is 0 is disabled. Port writes, validates and received packets for it are ignored, and `rxAccept`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| busReset | input | 1 | USB bus reset event, one cycle |
| selTx | input | 1 | Target of config/port access: 1 transmit, 0 receive |
| cfgNoEmpty | input | 1 | 1 suppresses the trailing zero-length packet |
| mpsWr | input | 1 | Write maximum packet size of selected buffer |
| mpsVal | input | PTR_W | Maximum packet size value |
| lenWr | input | 1 | Write count (buffer length) of selected buffer |
| lenVal | input | CNT_W | Count value |
| portAcc | input | 1 | Data-port access (write for transmit, read for receive) |
| portWide | input | 1 | 1 = 16-bit access, 0 = 8-bit access |
| validateCmd | input | 1 | Manual validate of transmit buffer |
| clearCmd | input | 1 | Manual clear of receive buffer |
| txSent | input | 1 | Packet engine sent the ready transmit packet |
| txSentBytes | input | PTR_W | Bytes in the sent packet |
| rxPkt | input | 1 | Packet engine acknowledged a received packet |
| rxBytes | input | PTR_W | Bytes in the received packet |
| txReady | output | 1 | Transmit buffer validated, awaiting send |
| txPktLen | output | PTR_W | Bytes written in the current transmit packet |
| txCount | output | CNT_W | Transmit bytes still to send |
| rxFull | output | 1 | Receive buffer holds unread data |
| rxAccept | output | 1 | Receive buffer enabled and free |
| rxShort | output | 1 | Last received packet was short |
| rxCount | output | CNT_W | Receive bytes still unread |
| rxPtr | output | PTR_W | Receive read pointer |
| portLowOnly | output | 1 | Current wide read returns only the low byte |

## Verification
Every cycle, the assertions check these properties:
- The transmit pointer never passes the maximum packet size.
- A bus reset always leaves both counts at zero with all flags clear.
- A validate on an enabled, idle buffer always yields a ready buffer.
- A disabled buffer never becomes ready.
- A full receive buffer holds its count against a new packet.
- Reading the final byte frees the receive buffer.
- An exact-boundary send leaves a zero-length packet pending.

Only the directed scenarios can show that the packet-splitting arithmetic works across a whole multi-packet transfer:
- the 16-bit stepping cap at an odd limit;
- the short-packet flag value;
- the suppression of the empty packet when `cfgNoEmpty` is set;
- the absence of an empty packet after a short final packet or a manually validated packet.

// File: rtl/eblm_pkg.sv
package eblm_pkg;
  localparam int IDX_RX  = 0;
  localparam int IDX_TX  = 1;
  localparam int NUM_BUF = 2;

  // Strobes from control to the per-buffer datapath; highest priority first.
  typedef struct packed {
    logic zeroAll;  // bus reset: count and pointer to zero
    logic loadMps;  // load max packet size, reload count
    logic loadLen;  // load count from length write
    logic pktEvt;   // packet sent (tx) or received (rx)
    logic adv;      // data-port access
    logic advTwo;   // access moves two bytes
    logic clrPtr;   // zero pointer
    logic clrCnt;   // zero count
  } bufStrobe_t;
endpackage

// File: rtl/eblm_dpath.sv
module eblm_dpath
  import eblm_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int PTR_W = 11
) (
  input  logic                               clk,
  input  logic                               rstN,
  input  bufStrobe_t [NUM_BUF-1:0]           strb,
  input  logic [PTR_W-1:0]                   mpsVal,
  input  logic [CNT_W-1:0]                   lenVal,
  input  logic [PTR_W-1:0]                   txSentBytes,
  input  logic [PTR_W-1:0]                   rxBytes,
  output logic [NUM_BUF-1:0][PTR_W-1:0]      mpsQ,
  output logic [NUM_BUF-1:0][PTR_W-1:0]      ptrQ,
  output logic [NUM_BUF-1:0][CNT_W-1:0]      cntQ
);

  for (genvar b = 0; b < NUM_BUF; b++) begin : g_buf
    localparam bit IS_TX = (b == IDX_TX);

    logic [PTR_W-1:0] mpsR;
    logic [PTR_W-1:0] ptrR;
    logic [CNT_W-1:0] cntR;
    logic [PTR_W-1:0] stepV;
    logic [CNT_W-1:0] evtCnt;

    assign stepV = strb[b].advTwo ? PTR_W'(2) : PTR_W'(1);

    if (IS_TX) begin : g_tx
      // Sent bytes come off the remaining transfer length, saturating.
      always_comb evtCnt = (cntR > CNT_W'(txSentBytes)) ? (cntR - CNT_W'(txSentBytes)) : '0;
    end else begin : g_rx
      // A received packet loads the unread count.
      always_comb evtCnt = CNT_W'(rxBytes);
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        mpsR <= '0;
        ptrR <= '0;
        cntR <= '0;
      end else if (strb[b].zeroAll) begin
        ptrR <= '0;
        cntR <= '0;
      end else if (strb[b].loadMps) begin
        mpsR <= mpsVal;
        cntR <= CNT_W'(mpsVal);
        ptrR <= '0;
      end else if (strb[b].loadLen) begin
        cntR <= lenVal;
        ptrR <= '0;
      end else if (strb[b].pktEvt) begin
        cntR <= evtCnt;
        ptrR <= '0;
      end else if (strb[b].adv) begin
        ptrR <= ptrR + stepV;
        if (!IS_TX) cntR <= cntR - CNT_W'(stepV);
      end else begin
        if (strb[b].clrPtr) ptrR <= '0;
        if (strb[b].clrCnt) cntR <= '0;
      end
    end

    assign mpsQ[b] = mpsR;
    assign ptrQ[b] = ptrR;
    assign cntQ[b] = cntR;

    if (IS_TX) begin : g_chk
      // R5: writes stop at the packet limit, never beyond max packet size
      p_tx_ptr_bound_r5: assert property (@(posedge clk) disable iff (!rstN)
        ptrR <= mpsR);
    end
  end

endmodule

// File: rtl/eblm_ctrl.sv
module eblm_ctrl
  import eblm_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int PTR_W = 11
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          busReset,
  input  logic                          selTx,
  input  logic                          cfgNoEmpty,
  input  logic                          mpsWr,
  input  logic                          lenWr,
  input  logic                          portAcc,
  input  logic                          portWide,
  input  logic                          validateCmd,
  input  logic                          clearCmd,
  input  logic                          txSent,
  input  logic [PTR_W-1:0]              txSentBytes,
  input  logic                          rxPkt,
  input  logic [PTR_W-1:0]              rxBytes,
  input  logic [NUM_BUF-1:0][PTR_W-1:0] mpsQ,
  input  logic [NUM_BUF-1:0][PTR_W-1:0] ptrQ,
  input  logic [NUM_BUF-1:0][CNT_W-1:0] cntQ,
  output bufStrobe_t [NUM_BUF-1:0]      strb,
  output logic                          txFull,
  output logic                          rxFull,
  output logic                          rxShort
);

  logic [PTR_W-1:0] txMps, txPtr, rxMps;
  logic [CNT_W-1:0] txCnt, rxCnt;
  logic             txEn, rxEn;
  logic [PTR_W-1:0] txLimit, txRoom;
  logic             txTwo, txAccept, txAuto, txZlp;
  logic [CNT_W-1:0] txNewCnt;
  logic             rxTwo, rxLast;
  logic             txFullNxt, rxFullNxt, rxShortNxt;

  assign txMps = mpsQ[IDX_TX];
  assign txPtr = ptrQ[IDX_TX];
  assign txCnt = cntQ[IDX_TX];
  assign rxMps = mpsQ[IDX_RX];
  assign rxCnt = cntQ[IDX_RX];
  assign txEn  = (txMps != '0);
  assign rxEn  = (rxMps != '0);

  // Packet limit: the smaller of remaining length and max packet size;
  // with no length programmed the whole packet space is usable.
  always_comb begin
    if (txCnt == '0)                  txLimit = txMps;
    else if (txCnt < CNT_W'(txMps))   txLimit = txCnt[PTR_W-1:0];
    else                              txLimit = txMps;
  end

  assign txRoom   = txLimit - txPtr;
  assign txAccept = txEn && !txFull && (txPtr < txLimit);
  assign txTwo    = portWide && (txRoom >= PTR_W'(2));
  assign txAuto   = (txCnt != '0) &&
                    (({1'b0, txPtr} + (txTwo ? (PTR_W+1)'(2) : (PTR_W+1)'(1))) >= {1'b0, txLimit});
  assign txNewCnt = (txCnt > CNT_W'(txSentBytes)) ? (txCnt - CNT_W'(txSentBytes)) : '0;
  assign txZlp    = txEn && (txCnt != '0) && (txNewCnt == '0) &&
                    (txSentBytes == txMps) && !cfgNoEmpty;

  assign rxTwo    = portWide && (rxCnt >= CNT_W'(2));
  assign rxLast   = rxTwo ? (rxCnt == CNT_W'(2)) : (rxCnt == CNT_W'(1));

  always_comb begin
    strb       = '0;
    txFullNxt  = txFull;
    rxFullNxt  = rxFull;
    rxShortNxt = rxShort;

    // ---------------- transmit buffer ----------------
    if (busReset) begin
      strb[IDX_TX].zeroAll = 1'b1;
      txFullNxt            = 1'b0;
    end else if (mpsWr && selTx) begin
      strb[IDX_TX].loadMps = 1'b1;
    end else if (lenWr && selTx) begin
      strb[IDX_TX].loadLen = 1'b1;
    end else if (validateCmd && txEn && !txFull) begin
      txFullNxt = 1'b1;
    end else if (txSent && txFull) begin
      strb[IDX_TX].pktEvt = 1'b1;
      txFullNxt           = txZlp;
    end else if (portAcc && selTx && txAccept) begin
      strb[IDX_TX].adv    = 1'b1;
      strb[IDX_TX].advTwo = txTwo;
      if (txAuto) txFullNxt = 1'b1;
    end

    // ---------------- receive buffer ----------------
    if (busReset) begin
      strb[IDX_RX].zeroAll = 1'b1;
      rxFullNxt            = 1'b0;
      rxShortNxt           = 1'b0;
    end else if (mpsWr && !selTx) begin
      strb[IDX_RX].loadMps = 1'b1;
    end else if (lenWr && !selTx) begin
      strb[IDX_RX].loadLen = 1'b1;
    end else if (clearCmd) begin
      strb[IDX_RX].clrPtr = 1'b1;
      strb[IDX_RX].clrCnt = 1'b1;
      rxFullNxt           = 1'b0;
    end else if (rxPkt && rxEn && !rxFull) begin
      strb[IDX_RX].pktEvt = 1'b1;
      rxFullNxt           = 1'b1;
      rxShortNxt          = (rxBytes < rxMps);
    end else if (portAcc && !selTx && rxFull && (rxCnt != '0)) begin
      strb[IDX_RX].adv    = 1'b1;
      strb[IDX_RX].advTwo = rxTwo;
      if (rxLast) rxFullNxt = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txFull  <= 1'b0;
      rxFull  <= 1'b0;
      rxShort <= 1'b0;
    end else begin
      txFull  <= txFullNxt;
      rxFull  <= rxFullNxt;
      rxShort <= rxShortNxt;
    end
  end

  // R4: a bus reset leaves no count and no pending buffer
  p_busrst_clear_r4: assert property (@(posedge clk) disable iff (!rstN)
    busReset |=> (cntQ[IDX_RX] == '0) && (cntQ[IDX_TX] == '0) && !txFull && !rxFull && !rxShort);

  // R10: validate on an enabled, idle transmit buffer makes it ready
  p_validate_r10: assert property (@(posedge clk) disable iff (!rstN)
    (validateCmd && txEn && !busReset && !mpsWr && !lenWr && !txSent) |=> txFull);

  // R11: a disabled transmit buffer never becomes ready
  p_disabled_r11: assert property (@(posedge clk) disable iff (!rstN)
    (!txEn && !txFull && !mpsWr && !lenWr) |=> !txFull);

  // R9: a full receive buffer ignores a new packet
  p_rx_locked_r9: assert property (@(posedge clk) disable iff (!rstN)
    (rxFull && rxPkt && !busReset && !mpsWr && !lenWr && !clearCmd && !portAcc)
      |=> (rxFull && $stable(cntQ[IDX_RX])));

  // R8: reading the final counted byte frees the receive buffer
  p_rx_autoclear_r8: assert property (@(posedge clk) disable iff (!rstN)
    (rxFull && portAcc && !selTx && (rxCnt == CNT_W'(1)) && !busReset && !mpsWr && !lenWr && !clearCmd)
      |=> !rxFull);

  // R7: an exact-boundary final packet leaves a zero-length packet pending
  p_zlp_r7: assert property (@(posedge clk) disable iff (!rstN)
    (txFull && txSent && txEn && (txCnt == CNT_W'(txMps)) && (txSentBytes == txMps) &&
     !cfgNoEmpty && !busReset && !mpsWr && !lenWr && !validateCmd)
      |=> (txFull && (ptrQ[IDX_TX] == '0) && (cntQ[IDX_TX] == '0)));

endmodule

// File: rtl/ep_buflen_mgr.sv
module ep_buflen_mgr
  import eblm_pkg::*;
#(
  parameter int MAX_PKT = 1024,
  parameter int CNT_W   = 16,
  localparam int PTR_W  = $clog2(MAX_PKT) + 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             busReset,
  input  logic             selTx,
  input  logic             cfgNoEmpty,
  input  logic             mpsWr,
  input  logic [PTR_W-1:0] mpsVal,
  input  logic             lenWr,
  input  logic [CNT_W-1:0] lenVal,
  input  logic             portAcc,
  input  logic             portWide,
  input  logic             validateCmd,
  input  logic             clearCmd,
  input  logic             txSent,
  input  logic [PTR_W-1:0] txSentBytes,
  input  logic             rxPkt,
  input  logic [PTR_W-1:0] rxBytes,
  output logic             txReady,
  output logic [PTR_W-1:0] txPktLen,
  output logic [CNT_W-1:0] txCount,
  output logic             rxFull,
  output logic             rxAccept,
  output logic             rxShort,
  output logic [CNT_W-1:0] rxCount,
  output logic [PTR_W-1:0] rxPtr,
  output logic             portLowOnly
);

  bufStrobe_t [NUM_BUF-1:0]      strb;
  logic [NUM_BUF-1:0][PTR_W-1:0] mpsQ;
  logic [NUM_BUF-1:0][PTR_W-1:0] ptrQ;
  logic [NUM_BUF-1:0][CNT_W-1:0] cntQ;
  logic                          txFull;

  eblm_ctrl #(.CNT_W(CNT_W), .PTR_W(PTR_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .busReset(busReset), .selTx(selTx),
    .cfgNoEmpty(cfgNoEmpty), .mpsWr(mpsWr), .lenWr(lenWr),
    .portAcc(portAcc), .portWide(portWide), .validateCmd(validateCmd),
    .clearCmd(clearCmd), .txSent(txSent), .txSentBytes(txSentBytes),
    .rxPkt(rxPkt), .rxBytes(rxBytes), .mpsQ(mpsQ), .ptrQ(ptrQ), .cntQ(cntQ),
    .strb(strb), .txFull(txFull), .rxFull(rxFull), .rxShort(rxShort)
  );

  eblm_dpath #(.CNT_W(CNT_W), .PTR_W(PTR_W)) u_dpath (
    .clk(clk), .rstN(rstN), .strb(strb), .mpsVal(mpsVal), .lenVal(lenVal),
    .txSentBytes(txSentBytes), .rxBytes(rxBytes),
    .mpsQ(mpsQ), .ptrQ(ptrQ), .cntQ(cntQ)
  );

  assign txReady     = txFull;
  assign txPktLen    = ptrQ[IDX_TX];
  assign txCount     = cntQ[IDX_TX];
  assign rxCount     = cntQ[IDX_RX];
  assign rxPtr       = ptrQ[IDX_RX];
  assign rxAccept    = (mpsQ[IDX_RX] != '0) && !rxFull;
  assign portLowOnly = !selTx && portWide && rxFull && (cntQ[IDX_RX] == CNT_W'(1));

endmodule

// File: tb/sim_ep_buflen_mgr.sv
`timescale 1ns/1ps
module sim_ep_buflen_mgr;
  localparam int MAX_PKT = 1024;
  localparam int CNT_W   = 16;
  localparam int PTR_W   = $clog2(MAX_PKT) + 1;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             busReset = 1'b0, selTx = 1'b0, cfgNoEmpty = 1'b0;
  logic             mpsWr = 1'b0, lenWr = 1'b0, portAcc = 1'b0, portWide = 1'b0;
  logic             validateCmd = 1'b0, clearCmd = 1'b0, txSent = 1'b0, rxPkt = 1'b0;
  logic [PTR_W-1:0] mpsVal = '0, txSentBytes = '0, rxBytes = '0;
  logic [CNT_W-1:0] lenVal = '0;
  logic             txReady, rxFull, rxAccept, rxShort, portLowOnly;
  logic [PTR_W-1:0] txPktLen, rxPtr;
  logic [CNT_W-1:0] txCount, rxCount;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  ep_buflen_mgr #(.MAX_PKT(MAX_PKT), .CNT_W(CNT_W)) u0 (
    .clk(clk), .rstN(rstN), .busReset(busReset), .selTx(selTx), .cfgNoEmpty(cfgNoEmpty),
    .mpsWr(mpsWr), .mpsVal(mpsVal), .lenWr(lenWr), .lenVal(lenVal),
    .portAcc(portAcc), .portWide(portWide), .validateCmd(validateCmd), .clearCmd(clearCmd),
    .txSent(txSent), .txSentBytes(txSentBytes), .rxPkt(rxPkt), .rxBytes(rxBytes),
    .txReady(txReady), .txPktLen(txPktLen), .txCount(txCount), .rxFull(rxFull),
    .rxAccept(rxAccept), .rxShort(rxShort), .rxCount(rxCount), .rxPtr(rxPtr),
    .portLowOnly(portLowOnly)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Each stimulus task drives for one clock; results are visible on return.
  task automatic doMps(input bit tx, input int v);
    @(negedge clk); selTx = tx; mpsVal = PTR_W'(v); mpsWr = 1'b1;
    @(negedge clk); mpsWr = 1'b0;
  endtask
  task automatic doLen(input bit tx, input int v);
    @(negedge clk); selTx = tx; lenVal = CNT_W'(v); lenWr = 1'b1;
    @(negedge clk); lenWr = 1'b0;
  endtask
  task automatic doPort(input bit tx, input bit wide);
    @(negedge clk); selTx = tx; portWide = wide; portAcc = 1'b1;
    @(negedge clk); portAcc = 1'b0;
  endtask
  task automatic doValidate();
    @(negedge clk); validateCmd = 1'b1;
    @(negedge clk); validateCmd = 1'b0;
  endtask
  task automatic doClear();
    @(negedge clk); clearCmd = 1'b1;
    @(negedge clk); clearCmd = 1'b0;
  endtask
  task automatic doSent(input int n);
    @(negedge clk); txSentBytes = PTR_W'(n); txSent = 1'b1;
    @(negedge clk); txSent = 1'b0;
  endtask
  task automatic doRx(input int n);
    @(negedge clk); rxBytes = PTR_W'(n); rxPkt = 1'b1;
    @(negedge clk); rxPkt = 1'b0;
  endtask
  task automatic doBusReset();
    @(negedge clk); busReset = 1'b1;
    @(negedge clk); busReset = 1'b0;
  endtask

  task automatic tReset();
    chk("R4 reset txReady", txReady, 0);
    chk("R4 reset rxFull", rxFull, 0);
    chk("R4 reset txCount", txCount, 0);
    chk("R4 reset rxCount", rxCount, 0);
    chk("R11 reset rxAccept (disabled)", rxAccept, 0);
  endtask

  task automatic tDisabled();
    doPort(1, 1);
    chk("R11 write to disabled tx", txPktLen, 0);
    doValidate();
    chk("R11 validate disabled tx", txReady, 0);
    doRx(4);
    chk("R11 packet to disabled rx", rxFull, 0);
    chk("R11 packet to disabled rx count", rxCount, 0);
  endtask

  task automatic tTxTransfer();
    doMps(1, 8);
    chk("R3 mps reloads tx count", txCount, 8);
    doLen(1, 20);
    chk("R3 length write", txCount, 20);
    for (int i = 0; i < 3; i++) doPort(1, 1);
    chk("R1 three wide writes", txPktLen, 6);
    chk("R5 not ready below limit", txReady, 0);
    doPort(1, 1);
    chk("R5 ready at max packet", txReady, 1);
    chk("R5 packet length", txPktLen, 8);
    doPort(1, 1);
    chk("R10 write while ready ignored", txPktLen, 8);
    doSent(8);
    chk("R6 count after send", txCount, 12);
    chk("R6 not ready after send", txReady, 0);
    chk("R6 pointer zero after send", txPktLen, 0);
    for (int i = 0; i < 4; i++) doPort(1, 1);
    chk("R5 second packet ready", txReady, 1);
    doSent(8);
    chk("R6 count after second send", txCount, 4);
    doPort(1, 0);
    chk("R1 narrow write step", txPktLen, 1);
    for (int i = 0; i < 3; i++) doPort(1, 0);
    chk("R5 short remainder ready", txReady, 1);
    chk("R5 short length", txPktLen, 4);
    doSent(4);
    chk("R7 no empty packet after short", txReady, 0);
    chk("R6 transfer finished", txCount, 0);
  endtask

  task automatic tZlp();
    doLen(1, 16);
    for (int p = 0; p < 2; p++) begin
      for (int i = 0; i < 4; i++) doPort(1, 1);
      doSent(8);
    end
    chk("R7 zero-length packet pending", txReady, 1);
    chk("R7 zero-length packet length", txPktLen, 0);
    doSent(0);
    chk("R7 zero-length packet sent", txReady, 0);
    cfgNoEmpty = 1'b1;
    doLen(1, 8);
    for (int i = 0; i < 4; i++) doPort(1, 1);
    doSent(8);
    chk("R7 no-empty option ends transfer", txReady, 0);
    cfgNoEmpty = 1'b0;
  endtask

  task automatic tWideCap();
    doLen(1, 3);
    doPort(1, 1);
    chk("R1 wide write step 2", txPktLen, 2);
    doPort(1, 1);
    chk("R1 wide write capped to 1", txPktLen, 3);
    chk("R5 odd limit ready", txReady, 1);
    doSent(3);
    chk("R6 odd transfer done", txCount, 0);
  endtask

  task automatic tManual();
    doLen(1, 0);
    for (int i = 0; i < 3; i++) doPort(1, 0);
    chk("R10 no auto-validate without length", txReady, 0);
    doValidate();
    chk("R10 manual validate", txReady, 1);
    chk("R10 manual length", txPktLen, 3);
    doValidate();
    chk("R10 second validate ignored", txPktLen, 3);
    doSent(3);
    chk("R10 manual packet sent, no empty packet", txReady, 0);
  endtask

  task automatic tRx();
    doMps(0, 8);
    chk("R3 mps reloads rx count", rxCount, 8);
    chk("R11 enabled rx accepts", rxAccept, 1);
    doRx(5);
    chk("R8 rx full", rxFull, 1);
    chk("R8 rx count", rxCount, 5);
    chk("R8 short flag", rxShort, 1);
    doRx(3);
    chk("R9 packet while full ignored", rxCount, 5);
    chk("R9 rxAccept low while full", rxAccept, 0);
    doPort(0, 1);
    chk("R1 wide read step", rxPtr, 2);
    doPort(0, 1);
    chk("R1 wide read count", rxCount, 1);
    @(negedge clk); selTx = 1'b0; portWide = 1'b1; #0.5;
    chk("R2 low-byte-only indication", portLowOnly, 1);
    doPort(0, 1);
    chk("R2 final odd byte step 1", rxPtr, 5);
    chk("R8 auto-clear after last byte", rxFull, 0);
    doRx(8);
    chk("R8 full-size not short", rxShort, 0);
    doClear();
    chk("R9 clear frees buffer", rxFull, 0);
    chk("R9 clear zeroes count", rxCount, 0);
    doRx(6);
    chk("R9 packet accepted after clear", rxCount, 6);
  endtask

  task automatic tBusReset();
    doLen(1, 10);
    doPort(1, 1);
    doBusReset();
    chk("R4 bus reset tx count", txCount, 0);
    chk("R4 bus reset tx pointer", txPktLen, 0);
    chk("R4 bus reset rx full", rxFull, 0);
    chk("R4 bus reset rx count", rxCount, 0);
    chk("R4 bus reset short flag", rxShort, 0);
    chk("R4 mps kept (rx still enabled)", rxAccept, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    tReset();
    tDisabled();
    tTxTransfer();
    tZlp();
    tWideCap();
    tManual();
    tRx();
    tBusReset();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual 0 expected 1 (run completed)");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule